// File: doc/BRIEF.md
# Shadowed Sink Setting Bank

This block holds the level settings for a row of programmable current-sink outputs. Every channel keeps two copies of its 4-bit level. The working copy drives the output straight away. The stored copy is a persistent snapshot, modelled as a plain register array. A host can therefore try out settings on the live outputs and commit them only once they sound right. It can also throw trial settings away by reloading the stored snapshot.

The host issues one command per transaction: read, write, save or restore. Each command carries a 7-bit address and 4 bits of data, and every transaction returns the addressed channel's contents on the next cycle. A save takes a fixed number of cycles. During that time the block reports busy and refuses any command that would change state.

Two static configuration pins choose how the outputs appear. One pin enables every channel. When that pin is low, the first four channels act as two complementary pairs, and the second pin picks which member of each pair drives.

Top module: `sink_setting_bank`

## Requirements
- R1: While `rst_n` is low, each working copy is loaded from its stored copy. After a reset, `busy` and `rsp_valid` are low. `store_rst_n` clears the stored copies to zero.
- R2: Channel n (1 to 8) sits at address 7'h08 + (n-1). A write (`cmd_op` = 2'b01) changes only that channel's working copy.
- R3: An address outside 7'h08..7'h0F is ignored by a write and replies with data zero.
- R4: An accepted command raises `rsp_valid` for exactly the following cycle. `rsp_data` then holds the addressed channel's working value as it stands after the command.
- R5: A write changes the working copy only. A restore (`cmd_op` = 2'b11) reloads every working copy from its stored copy.
- R6: A save (`cmd_op` = 2'b10) copies every working value into the stored copies. `busy` is then high for SAVE_CYCLES cycles.
- R7: While `busy` is high, a write, restore or save is rejected: `rsp_reject` is high with the response and no state changes. A read (`cmd_op` = 2'b00) is still served, with `rsp_reject` low.
- R8: With `cfg_all_on` high, all eight outputs are enabled and show their working levels.
- R9: With `cfg_all_on` low, channels 5 to 8 stay enabled. With `cfg_pair_sel` low, channels 1 and 3 are disabled and channels 2 and 4 drive.
- R10: With `cfg_all_on` low and `cfg_pair_sel` high, channels 2 and 4 are disabled and channels 1 and 3 drive.
- R11: A disabled output shows level zero with its enable bit low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; reloads the working copies |
| store_rst_n | input | 1 | Synchronous active-low clear of the stored copies (power-up) |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 00 read, 01 write, 10 save, 11 restore |
| cmd_addr | input | 7 | Register address |
| cmd_data | input | 4 | Write level |
| cfg_all_on | input | 1 | High: all channels enabled |
| cfg_pair_sel | input | 1 | Pair member select when `cfg_all_on` is low |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | 4 | Addressed channel contents |
| rsp_reject | output | 1 | Command was refused because of busy |
| busy | output | 1 | Save in progress |
| out_level | output | 32 | Channel levels, channel 1 in bits 3:0 |
| out_en | output | 8 | Channel enables, channel 1 in bit 0 |

## Verification
The bench builds the block with eight 4-bit channels, base address 7'h08 and SAVE_CYCLES set to 3. With those values it can sweep every level on every channel and read all 128 addresses. It can also visit all four pin combinations for each channel. The short save window lets the bench place rejected writes and restores on each busy cycle and check the first cycle after busy drops.

// File: rtl/sink_bank_pkg.sv
package sink_bank_pkg;
   typedef enum logic [1:0] {
      OP_READ    = 2'b00,
      OP_WRITE   = 2'b01,
      OP_SAVE    = 2'b10,
      OP_RESTORE = 2'b11
   } sink_op_e;
endpackage

// File: rtl/sink_bank_regs.sv
module sink_bank_regs #(
   parameter int NUM_CH = 8,
   parameter int LVL_W  = 4,
   localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          store_rst_n,
   input  logic                          wr_en,
   input  logic [IDX_W-1:0]              wr_idx,
   input  logic [LVL_W-1:0]              wr_data,
   input  logic                          save,
   input  logic                          restore,
   output logic [NUM_CH-1:0][LVL_W-1:0]  work,
   output logic [NUM_CH-1:0][LVL_W-1:0]  store
);
   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      // working copy: drives the output, reloaded on reset or restore
      always_ff @(posedge clk) begin
         if (!rst_n || restore)
            work[i] <= store[i];
         else if (wr_en && (wr_idx == IDX_W'(i)))
            work[i] <= wr_data;
      end

      // stored copy: survives rst_n, cleared only at power-up
      always_ff @(posedge clk) begin
         if (!store_rst_n)
            store[i] <= '0;
         else if (save)
            store[i] <= work[i];
      end
   end
endmodule

// File: rtl/sink_bank_busy.sv
module sink_bank_busy #(
   parameter int SAVE_CYCLES = 4,
   localparam int CNT_W = $clog2(SAVE_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   logic [CNT_W-1:0] remain;

   always_ff @(posedge clk) begin
      if (!rst_n)
         remain <= '0;
      else if (start)
         remain <= CNT_W'(SAVE_CYCLES);
      else if (remain != '0)
         remain <= remain - 1'b1;
   end

   assign busy = (remain != '0);
endmodule

// File: rtl/sink_bank_outmux.sv
module sink_bank_outmux #(
   parameter int NUM_CH  = 8,
   parameter int LVL_W   = 4,
   parameter int PAIR_CH = 4
) (
   input  logic [NUM_CH-1:0][LVL_W-1:0] work,
   input  logic                         all_on,
   input  logic                         pair_sel,
   output logic [NUM_CH-1:0][LVL_W-1:0] level,
   output logic [NUM_CH-1:0]            en
);
   for (genvar i = 0; i < NUM_CH; i++) begin : g_out
      if (i >= PAIR_CH) begin : g_fixed
         assign en[i] = 1'b1;
      end else if ((i % 2) == 0) begin : g_first
         assign en[i] = all_on | pair_sel;
      end else begin : g_second
         assign en[i] = all_on | ~pair_sel;
      end
      assign level[i] = en[i] ? work[i] : '0;
   end
endmodule

// File: rtl/sink_setting_bank.sv
module sink_setting_bank
   import sink_bank_pkg::*;
#(
   parameter int              NUM_CH      = 8,
   parameter int              LVL_W       = 4,
   parameter int              ADDR_W      = 7,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 7'h08,
   parameter int              PAIR_CH     = 4,
   parameter int              SAVE_CYCLES = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      store_rst_n,
   input  logic                      cmd_valid,
   input  logic [1:0]                cmd_op,
   input  logic [ADDR_W-1:0]         cmd_addr,
   input  logic [LVL_W-1:0]          cmd_data,
   input  logic                      cfg_all_on,
   input  logic                      cfg_pair_sel,
   output logic                      rsp_valid,
   output logic [LVL_W-1:0]          rsp_data,
   output logic                      rsp_reject,
   output logic                      busy,
   output logic [NUM_CH*LVL_W-1:0]   out_level,
   output logic [NUM_CH-1:0]         out_en
);
   localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   if ((PAIR_CH % 2) != 0 || PAIR_CH > NUM_CH) begin : g_bad_pair
      $error("PAIR_CH must be even and no larger than NUM_CH");
   end
   if (int'(BASE_ADDR) + NUM_CH > (1 << ADDR_W)) begin : g_bad_addr
      $error("channel window runs past the address space");
   end
   if (SAVE_CYCLES < 1) begin : g_bad_save
      $error("SAVE_CYCLES must be at least 1");
   end

   sink_op_e                    op;
   logic [ADDR_W:0]             offset;
   logic                        hit;
   logic [IDX_W-1:0]            idx;
   logic                        wr_ok, save_ok, restore_ok, refuse;
   logic [NUM_CH-1:0][LVL_W-1:0] work, store, level;
   logic [LVL_W-1:0]            reply;

   assign op     = sink_op_e'(cmd_op);
   assign offset = {1'b0, cmd_addr} - {1'b0, BASE_ADDR};
   assign hit    = (cmd_addr >= BASE_ADDR) && (offset < (ADDR_W+1)'(NUM_CH));
   assign idx    = offset[IDX_W-1:0];

   assign wr_ok      = cmd_valid && !busy && (op == OP_WRITE) && hit;
   assign save_ok    = cmd_valid && !busy && (op == OP_SAVE);
   assign restore_ok = cmd_valid && !busy && (op == OP_RESTORE);
   assign refuse     = cmd_valid && busy && (op != OP_READ);

   sink_bank_regs #(.NUM_CH(NUM_CH), .LVL_W(LVL_W)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .store_rst_n (store_rst_n),
      .wr_en       (wr_ok),
      .wr_idx      (idx),
      .wr_data     (cmd_data),
      .save        (save_ok),
      .restore     (restore_ok),
      .work        (work),
      .store       (store)
   );

   sink_bank_busy #(.SAVE_CYCLES(SAVE_CYCLES)) u_busy (
      .clk   (clk),
      .rst_n (rst_n),
      .start (save_ok),
      .busy  (busy)
   );

   sink_bank_outmux #(.NUM_CH(NUM_CH), .LVL_W(LVL_W), .PAIR_CH(PAIR_CH)) u_out (
      .work     (work),
      .all_on   (cfg_all_on),
      .pair_sel (cfg_pair_sel),
      .level    (level),
      .en       (out_en)
   );

   assign out_level = level;

   // reply reflects the addressed value after this command takes effect
   always_comb begin
      if (!hit)
         reply = '0;
      else if (wr_ok)
         reply = cmd_data;
      else if (restore_ok)
         reply = store[idx];
      else
         reply = work[idx];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_data   <= '0;
         rsp_reject <= 1'b0;
      end else begin
         rsp_valid  <= cmd_valid;
         rsp_data   <= cmd_valid ? reply : '0;
         rsp_reject <= refuse;
      end
   end
endmodule

// File: rtl/sink_setting_bank_chk.sv
module sink_setting_bank_chk #(
   parameter int NUM_CH  = 8,
   parameter int LVL_W   = 4,
   parameter int ADDR_W  = 7,
   parameter int PAIR_CH = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    cmd_valid,
   input logic [1:0]              cmd_op,
   input logic                    cfg_all_on,
   input logic                    cfg_pair_sel,
   input logic                    rsp_valid,
   input logic                    rsp_reject,
   input logic                    busy,
   input logic [NUM_CH*LVL_W-1:0] out_level,
   input logic [NUM_CH-1:0]       out_en
);
   // R4
   rsp_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> rsp_valid);

   // R4
   no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> !rsp_valid);

   // R6
   save_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 2'b10 && !busy) |=> busy);

   // R7
   busy_write_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && busy && cmd_op != 2'b00) |=> rsp_reject);

   // R7
   read_never_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 2'b00) |=> !rsp_reject);

   // R8
   all_on_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_all_on |-> (&out_en));

   // R9
   fixed_channels_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&out_en[NUM_CH-1:PAIR_CH]));

   for (genvar p = 0; p < PAIR_CH; p += 2) begin : g_pair
      // R10
      pair_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !cfg_all_on |-> (out_en[p] != out_en[p+1]));
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_dark
      // R11
      dark_level_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !out_en[i] |-> (out_level[i*LVL_W +: LVL_W] == '0));
   end
endmodule

bind sink_setting_bank sink_setting_bank_chk #(
   .NUM_CH(NUM_CH), .LVL_W(LVL_W), .ADDR_W(ADDR_W), .PAIR_CH(PAIR_CH)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cmd_valid    (cmd_valid),
   .cmd_op       (cmd_op),
   .cfg_all_on   (cfg_all_on),
   .cfg_pair_sel (cfg_pair_sel),
   .rsp_valid    (rsp_valid),
   .rsp_reject   (rsp_reject),
   .busy         (busy),
   .out_level    (out_level),
   .out_en       (out_en)
);

// File: tb/sink_setting_bank_bench.sv
module sink_setting_bank_bench;
   localparam int NCH = 8;
   localparam int LW  = 4;
   localparam int SC  = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0, store_rst_n = 1'b0;
   logic cmd_valid = 1'b0;
   logic [1:0] cmd_op = 2'b00;
   logic [6:0] cmd_addr = '0;
   logic [3:0] cmd_data = '0;
   logic cfg_all_on = 1'b1, cfg_pair_sel = 1'b0;
   logic rsp_valid, rsp_reject, busy;
   logic [3:0] rsp_data;
   logic [NCH*LW-1:0] out_level;
   logic [NCH-1:0] out_en;

   int total = 0, bad = 0;
   int mw[NCH];
   int mp[NCH];
   int got_data, got_valid, got_rej;

   always #10 clk = ~clk;

   sink_setting_bank #(.SAVE_CYCLES(SC)) u_sink_setting_bank (
      .clk(clk), .rst_n(rst_n), .store_rst_n(store_rst_n),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
      .cmd_data(cmd_data), .cfg_all_on(cfg_all_on), .cfg_pair_sel(cfg_pair_sel),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_reject(rsp_reject),
      .busy(busy), .out_level(out_level), .out_en(out_en)
   );

   task automatic chk(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // call at a negedge; returns at the next negedge with the response captured
   task automatic cmd(int op, int addr, int data);
      cmd_valid = 1'b1;
      cmd_op    = 2'(op);
      cmd_addr  = 7'(addr);
      cmd_data  = 4'(data);
      @(negedge clk);
      got_valid = rsp_valid;
      got_data  = rsp_data;
      got_rej   = rsp_reject;
      cmd_valid = 1'b0;
   endtask

   function automatic int exp_en(int i);
      if (cfg_all_on || i >= 4) return 1;
      return ((i % 2) == 0) == cfg_pair_sel ? 1 : 0;
   endfunction

   task automatic check_outputs(string req);
      for (int i = 0; i < NCH; i++) begin
         chk(req, out_en[i], exp_en(i));
         chk(req, out_level[i*LW +: LW], exp_en(i) ? mw[i] : 0);
      end
   endtask

   initial begin
      #(200000 * 20);
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < NCH; i++) begin mw[i] = 0; mp[i] = 0; end
      repeat (3) @(negedge clk);
      store_rst_n = 1'b1;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 busy", busy, 0);
      chk("R1 rsp_valid", rsp_valid, 0);
      check_outputs("R1");

      // R2 R4 sweep every level on every channel
      for (int c = 0; c < NCH; c++)
         for (int l = 0; l < 16; l++) begin
            cmd(1, 8 + c, l);
            mw[c] = l;
            chk("R4 valid", got_valid, 1);
            chk("R4 data", got_data, l);
            check_outputs("R2");
         end
      for (int c = 0; c < NCH; c++) begin
         cmd(1, 8 + c, (c * 3 + 1) % 16);
         mw[c] = (c * 3 + 1) % 16;
      end

      // R3 R4 read every address; writes outside the window are ignored
      for (int a = 0; a < 128; a++) begin
         cmd(0, a, 0);
         chk("R4 read", got_data, (a >= 8 && a < 16) ? mw[a - 8] : 0);
         if (a < 8 || a >= 16) begin
            cmd(1, a, 4'hA);
            chk("R3 reply", got_data, 0);
            check_outputs("R3");
         end
      end

      // R6 R7 save and busy window
      cmd(2, 8, 0);
      for (int i = 0; i < NCH; i++) mp[i] = mw[i];
      chk("R6 busy", busy, 1);
      chk("R6 reject", got_rej, 0);
      cmd(1, 9, 0);
      chk("R7 write refused", got_rej, 1);
      chk("R7 data", got_data, mw[1]);
      chk("R6 busy2", busy, 1);
      cmd(3, 9, 0);
      chk("R7 restore refused", got_rej, 1);
      chk("R6 busy3", busy, 1);
      cmd(0, 10, 0);
      chk("R7 read served", got_rej, 0);
      chk("R7 read data", got_data, mw[2]);
      chk("R6 busy end", busy, 0);
      check_outputs("R7");

      // R5 trial writes then restore
      for (int c = 0; c < NCH; c++) begin
         cmd(1, 8 + c, 15 - c);
         mw[c] = 15 - c;
      end
      check_outputs("R5 trial");
      cmd(3, 12, 0);
      for (int i = 0; i < NCH; i++) mw[i] = mp[i];
      chk("R5 restore reply", got_data, mp[4]);
      check_outputs("R5 restore");

      // R1 reset reloads the stored copy
      for (int c = 0; c < NCH; c++) cmd(1, 8 + c, 7);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 busy after reset", busy, 0);
      check_outputs("R1 reload");

      // R8 R9 R10 R11 configuration sweep
      for (int k = 0; k < 4; k++) begin
         cfg_all_on   = k[1];
         cfg_pair_sel = k[0];
         @(negedge clk);
         check_outputs(k >= 2 ? "R8" : (k == 0 ? "R9 R11" : "R10 R11"));
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule